// File: doc/BRIEF.md
# Atomic Register-Memory Exchange Unit

This execution unit performs a swap instruction whose bytes have already been fetched and decoded far enough to expose the opcode, the three ModR/M fields, an operand-size flag and a precomputed effective address. It trades the contents of two operands. Both can be general registers, or one can be a register and the other a location in memory. Byte, word and doubleword operand sizes are supported. The unit does not own the general register file. It reads and writes an external eight-entry, 32-bit file through two read ports and two write ports. It reaches memory over a simple request interface with a ready handshake.

A swap that touches memory is made indivisible by a bus-lock output. Lock is raised before the read and held without a gap through the write. It is raised whether or not a lock prefix was present, so a semaphore built on this swap is safe. Register-only swaps complete in a single cycle and never lock. The unit neither reads nor changes any status flag. It accepts a new instruction only while idle, and it reports each completion with a one-cycle pulse.

Top module: `xchg_unit`

## Requirements
- R1: While reset is held and after it is released, done_o, lock_o, mem_req_o, rf_we_a_o and rf_we_b_o are all low until an instruction is accepted.
- R2: Opcodes 0x91 to 0x97 swap register 0 with the register numbered by opcode bits 2:0. With opsize32_i=1 all 32 bits are swapped. With opsize32_i=0 only bits 15:0 are swapped and bits 31:16 of both registers are kept. done_o is high in the cycle after acceptance and lock_o stays low.
- R3: Opcode 0x90 raises done_o in the cycle after acceptance. It performs no register write and no memory request, and it changes no state.
- R4: Opcode 0x86 with mod=3 swaps two byte registers named by the reg and rm fields. Byte numbers 0-3 name bits 7:0 of registers 0-3, and byte numbers 4-7 name bits 15:8 of registers 0-3. Every other bit is kept.
- R5: When both operands of a register-only swap live in the same physical register, the unit issues one write on port A that holds the combined result, and rf_we_b_o stays low. Port B writes only when the two physical registers differ. An example is byte 0 with byte 4, where the two bytes are exchanged.
- R6: Opcode 0x87 with mod=3 swaps the register named by reg with the register named by rm. The swap is 32 bits wide when opsize32_i=1 and 16 bits wide otherwise, and it keeps bits 31:16 in the 16-bit case.
- R7: For 0x86 or 0x87 with mod not equal to 3, lock_o rises in the cycle after acceptance. A read request is then held with mem_we_o=0, mem_addr_o set to the effective address and mem_size_o set to the size code (0 byte, 1 word, 2 doubleword) until mem_ready_i is seen. A write request follows and is held until ready. It has the same address and size and carries the register operand's old value zero-extended. lock_o stays high without a break from the first read cycle through the last write cycle.
- R8: In the cycle after the write handshake, lock_o is low and done_o is high. The register operand receives the low bits of the data read, and its other bits are kept.
- R9: done_o is a one-cycle pulse. A start_i seen while an exchange is in progress is ignored.
- R10: Any other opcode completes like R3, with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction valid; taken only when idle |
| opcode_i | input | 8 | Primary opcode byte |
| modrm_mod_i | input | 2 | ModR/M mod field |
| modrm_reg_i | input | 3 | ModR/M reg field |
| modrm_rm_i | input | 3 | ModR/M rm field |
| opsize32_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit (non-byte forms) |
| ea_i | input | 32 | Effective address of the memory operand |
| rf_raddr_a_o | output | 3 | Register read port A address |
| rf_rdata_a_i | input | 32 | Register read port A data |
| rf_raddr_b_o | output | 3 | Register read port B address |
| rf_rdata_b_i | input | 32 | Register read port B data |
| rf_we_a_o | output | 1 | Write port A enable |
| rf_waddr_a_o | output | 3 | Write port A address |
| rf_wdata_a_o | output | 32 | Write port A data (full register) |
| rf_we_b_o | output | 1 | Write port B enable |
| rf_waddr_b_o | output | 3 | Write port B address |
| rf_wdata_b_o | output | 32 | Write port B data (full register) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 32 | Write data, operand in the low bits |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Completes the current request |
| lock_o | output | 1 | Bus lock |
| done_o | output | 1 | Exchange complete pulse |

## Verification
A register-only or no-effect instruction is due in the cycle after the accepting edge. The memory form runs as follows: lock and the read request appear in the cycle after acceptance, the write request in the cycle after the read handshake, and done in the cycle after the write handshake. Register-file contents change one edge after the cycle that shows the write enable. The bench drives every input on the falling edge and checks the ports on the falling edge of each of these cycles, with the ready latency varied per instruction. One falling edge later it compares the whole register file and the addressed memory word against its own model.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  // Operand size codes; the value also travels on the memory size output.
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } opsz_e;

  // Sequencer states.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REG  = 3'd1,
    ST_MRD  = 3'd2,
    ST_MWR  = 3'd3,
    ST_WB   = 3'd4
  } xst_e;

  // Decoded exchange: ra is the register operand, rb the other one.
  typedef struct packed {
    logic       nop;
    logic       mem;
    opsz_e      size;
    logic [2:0] ra;
    logic [2:0] rb;
  } xop_t;

  localparam logic [4:0] OPC_ACC_HI  = 5'b10010;
  localparam logic [7:0] OPC_BYTE    = 8'h86;
  localparam logic [7:0] OPC_FULL    = 8'h87;
  localparam logic [1:0] MOD_REGONLY = 2'b11;

  // Physical register that holds an operand of the given size.
  function automatic logic [2:0] phys_of(opsz_e s, logic [2:0] r);
    return (s == SZ_BYTE) ? {1'b0, r[1:0]} : r;
  endfunction

endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
  import xchg_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] reg_i,
  input  logic [2:0] rm_i,
  input  logic       opsize32_i,
  output xop_t       op_o
);

  opsz_e full_sz;

  always_comb begin
    full_sz = opsize32_i ? SZ_DWORD : SZ_WORD;
    op_o      = '0;
    op_o.nop  = 1'b1;
    op_o.size = SZ_BYTE;
    if (opcode_i[7:3] == OPC_ACC_HI) begin
      op_o.nop  = (opcode_i[2:0] == 3'd0);
      op_o.size = full_sz;
      op_o.ra   = 3'd0;
      op_o.rb   = opcode_i[2:0];
    end else if (opcode_i == OPC_BYTE || opcode_i == OPC_FULL) begin
      op_o.nop  = 1'b0;
      op_o.mem  = (mod_i != MOD_REGONLY);
      op_o.size = opcode_i[0] ? full_sz : SZ_BYTE;
      op_o.ra   = reg_i;
      op_o.rb   = rm_i;
    end
  end

endmodule

// File: rtl/xchg_pick.sv
module xchg_pick
  import xchg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opsz_e              size_i,
  input  logic               hi_i,
  input  logic [DATA_W-1:0]  word_i,
  output logic [DATA_W-1:0]  val_o
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 2 * BYTE_W;

  always_comb begin
    val_o = '0;
    case (size_i)
      SZ_BYTE: val_o[BYTE_W-1:0] = hi_i ? word_i[HALF_W-1:BYTE_W] : word_i[BYTE_W-1:0];
      SZ_WORD: val_o[HALF_W-1:0] = word_i[HALF_W-1:0];
      default: val_o = word_i;
    endcase
  end

endmodule

// File: rtl/xchg_merge.sv
module xchg_merge
  import xchg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opsz_e              size_i,
  input  logic               hi_i,
  input  logic [DATA_W-1:0]  word_i,
  input  logic [DATA_W-1:0]  val_i,
  output logic [DATA_W-1:0]  word_o
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 2 * BYTE_W;

  always_comb begin
    word_o = word_i;
    case (size_i)
      SZ_BYTE: begin
        if (hi_i) word_o[HALF_W-1:BYTE_W] = val_i[BYTE_W-1:0];
        else      word_o[BYTE_W-1:0]      = val_i[BYTE_W-1:0];
      end
      SZ_WORD: word_o[HALF_W-1:0] = val_i[HALF_W-1:0];
      default: word_o = val_i;
    endcase
  end

endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mem_form_i,
  input  logic mem_ready_i,
  output xst_e state_o,
  output logic accept_o,
  output logic lock_o
);

  xst_e state_q, state_d;
  logic lock_q, lock_d;

  always_comb begin
    state_d  = state_q;
    lock_d   = lock_q;
    accept_o = (state_q == ST_IDLE) && start_i;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = mem_form_i ? ST_MRD : ST_REG;
          lock_d  = mem_form_i;
        end
      end
      ST_REG:  state_d = ST_IDLE;
      ST_MRD:  if (mem_ready_i) state_d = ST_MWR;
      ST_MWR: begin
        if (mem_ready_i) begin
          state_d = ST_WB;
          lock_d  = 1'b0;
        end
      end
      ST_WB:   state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        lock_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign state_o = state_q;
  assign lock_o  = lock_q;

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
  import xchg_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [7:0]                   opcode_i,
  input  logic [1:0]                   modrm_mod_i,
  input  logic [2:0]                   modrm_reg_i,
  input  logic [2:0]                   modrm_rm_i,
  input  logic                         opsize32_i,
  input  logic [ADDR_W-1:0]            ea_i,
  output logic [$clog2(NUM_REGS)-1:0]  rf_raddr_a_o,
  input  logic [DATA_W-1:0]            rf_rdata_a_i,
  output logic [$clog2(NUM_REGS)-1:0]  rf_raddr_b_o,
  input  logic [DATA_W-1:0]            rf_rdata_b_i,
  output logic                         rf_we_a_o,
  output logic [$clog2(NUM_REGS)-1:0]  rf_waddr_a_o,
  output logic [DATA_W-1:0]            rf_wdata_a_o,
  output logic                         rf_we_b_o,
  output logic [$clog2(NUM_REGS)-1:0]  rf_waddr_b_o,
  output logic [DATA_W-1:0]            rf_wdata_b_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [1:0]                   mem_size_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  input  logic [DATA_W-1:0]            mem_rdata_i,
  input  logic                         mem_ready_i,
  output logic                         lock_o,
  output logic                         done_o
);

  localparam int unsigned RF_AW   = $clog2(NUM_REGS);
  localparam int unsigned N_SIDES = 2;

  // Reset: asserted asynchronously, released through a flop chain.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  // Decode and sequencing.
  xop_t op_dec, op_q;
  xst_e state;
  logic accept;

  xchg_decode u_dec (
    .opcode_i   (opcode_i),
    .mod_i      (modrm_mod_i),
    .reg_i      (modrm_reg_i),
    .rm_i       (modrm_rm_i),
    .opsize32_i (opsize32_i),
    .op_o       (op_dec)
  );

  xchg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .mem_form_i  (op_dec.mem),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .accept_o    (accept),
    .lock_o      (lock_o)
  );

  // Instruction and memory-data holding registers.
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mdata_q;
  logic              mdata_en;

  assign mdata_en = (state == ST_MRD) && mem_ready_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q   <= '0;
      addr_q <= '0;
    end else if (accept) begin
      op_q   <= op_dec;
      addr_q <= ea_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    mdata_q <= '0;
    else if (mdata_en) mdata_q <= mem_rdata_i;
  end

  // Operand lanes: side 0 is the register operand, side 1 the other one.
  logic [2:0]        phys [N_SIDES];
  logic [2:0]        spec [N_SIDES];
  logic [DATA_W-1:0] rword [N_SIDES];
  logic [DATA_W-1:0] opval [N_SIDES];
  logic [DATA_W-1:0] inval [N_SIDES];
  logic [DATA_W-1:0] putw  [N_SIDES];
  logic [DATA_W-1:0] put_both;
  logic              same_phys;

  assign spec[0]  = op_q.ra;
  assign spec[1]  = op_q.rb;
  assign rword[0] = rf_rdata_a_i;
  assign rword[1] = rf_rdata_b_i;
  assign inval[0] = op_q.mem ? mdata_q : opval[1];
  assign inval[1] = opval[0];

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    assign phys[g] = phys_of(op_q.size, spec[g]);

    xchg_pick #(.DATA_W(DATA_W)) u_pick (
      .size_i (op_q.size),
      .hi_i   (spec[g][2]),
      .word_i (rword[g]),
      .val_o  (opval[g])
    );

    xchg_merge #(.DATA_W(DATA_W)) u_merge (
      .size_i (op_q.size),
      .hi_i   (spec[g][2]),
      .word_i (rword[g]),
      .val_i  (inval[g]),
      .word_o (putw[g])
    );
  end

  // Both operands in one physical register: fold second insert onto first.
  xchg_merge #(.DATA_W(DATA_W)) u_merge_same (
    .size_i (op_q.size),
    .hi_i   (spec[1][2]),
    .word_i (putw[0]),
    .val_i  (opval[0]),
    .word_o (put_both)
  );

  assign same_phys = (phys[0] == phys[1]);

  // Register file ports.
  assign rf_raddr_a_o = RF_AW'(phys[0]);
  assign rf_raddr_b_o = RF_AW'(phys[1]);

  always_comb begin
    rf_we_a_o    = 1'b0;
    rf_we_b_o    = 1'b0;
    rf_waddr_a_o = RF_AW'(phys[0]);
    rf_waddr_b_o = RF_AW'(phys[1]);
    rf_wdata_a_o = putw[0];
    rf_wdata_b_o = putw[1];
    if (state == ST_REG && !op_q.nop) begin
      rf_we_a_o = 1'b1;
      rf_we_b_o = !same_phys;
      if (same_phys) rf_wdata_a_o = put_both;
    end else if (state == ST_WB) begin
      rf_we_a_o = 1'b1;
    end
  end

  // Memory side.
  assign mem_req_o   = (state == ST_MRD) || (state == ST_MWR);
  assign mem_we_o    = (state == ST_MWR);
  assign mem_addr_o  = addr_q;
  assign mem_size_o  = op_q.size;
  assign mem_wdata_o = opval[0];
  assign done_o      = (state == ST_REG) || (state == ST_WB);

endmodule

// File: rtl/xchg_unit_chk.sv
module xchg_unit_chk #(
  parameter int unsigned RF_AW  = 3,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rf_we_a_o,
  input logic              rf_we_b_o,
  input logic [RF_AW-1:0]  rf_waddr_a_o,
  input logic [RF_AW-1:0]  rf_waddr_b_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic              lock_o,
  input logic              done_o
);

  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> lock_o); // R7

  AST_LOCK_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> mem_req_o); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o)); // R7

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(mem_req_o && mem_ready_i)); // R7

  AST_DONE_ON_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> done_o); // R8

  AST_NO_RF_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> !(rf_we_a_o || rf_we_b_o)); // R8

  AST_DUAL_WRITE_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_b_o |-> (rf_we_a_o && rf_waddr_a_o != rf_waddr_b_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

endmodule

bind xchg_unit xchg_unit_chk #(.RF_AW($clog2(NUM_REGS)), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rf_we_a_o    (rf_we_a_o),
  .rf_we_b_o    (rf_we_b_o),
  .rf_waddr_a_o (rf_waddr_a_o),
  .rf_waddr_b_o (rf_waddr_b_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ready_i  (mem_ready_i),
  .lock_o       (lock_o),
  .done_o       (done_o)
);

// File: tb/xchg_unit_test.sv
module xchg_unit_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic [1:0]  md;
  logic [2:0]  rg, rm;
  logic        o32;
  logic [31:0] ea;
  logic [2:0]  raddr_a, raddr_b, waddr_a, waddr_b;
  logic [31:0] rdata_a, rdata_b, wdata_a, wdata_b;
  logic        we_a, we_b;
  logic        mreq, mwe, mready, lock, done;
  logic [31:0] maddr, mwdata, mrdata;
  logic [1:0]  msize;

  logic [31:0] rf     [8];
  logic [31:0] mem_m  [16];
  logic [31:0] exp_rf [8];
  logic [31:0] exp_mem[16];

  int tests = 0;
  int fails = 0;

  xchg_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opcode),
    .modrm_mod_i(md), .modrm_reg_i(rg), .modrm_rm_i(rm), .opsize32_i(o32),
    .ea_i(ea),
    .rf_raddr_a_o(raddr_a), .rf_rdata_a_i(rdata_a),
    .rf_raddr_b_o(raddr_b), .rf_rdata_b_i(rdata_b),
    .rf_we_a_o(we_a), .rf_waddr_a_o(waddr_a), .rf_wdata_a_o(wdata_a),
    .rf_we_b_o(we_b), .rf_waddr_b_o(waddr_b), .rf_wdata_b_o(wdata_b),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_size_o(msize),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ready_i(mready),
    .lock_o(lock), .done_o(done)
  );

  function automatic logic [31:0] size_mask(int sz);
    return (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mmerge(int sz, logic [31:0] old, logic [31:0] v);
    return (old & ~size_mask(sz)) | (v & size_mask(sz));
  endfunction

  // External register file and memory models.
  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];
  assign mrdata  = mem_m[maddr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++)
        rf[i] <= {8'(8'hA0 + i), 8'(8'hB1 + i), 8'(8'hC2 + i), 8'(8'hD3 + i)};
      for (int i = 0; i < 16; i++)
        mem_m[i] <= {8'(8'h50 + i), 8'(8'h61 + i), 8'(8'h72 + i), 8'(8'h83 + i)};
    end else begin
      if (we_a) rf[waddr_a] <= wdata_a;
      if (we_b) rf[waddr_b] <= wdata_b;
      if (mreq && mwe && mready) mem_m[maddr[3:0]] <= mmerge(int'(msize), mem_m[maddr[3:0]], mwdata);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural operand access on the expected register file.
  function automatic logic [31:0] rget(int sz, int spec);
    logic [31:0] w;
    if (sz == 0) begin
      w = exp_rf[spec % 4];
      return (spec >= 4) ? ((w >> 8) & 32'hFF) : (w & 32'hFF);
    end
    return exp_rf[spec] & size_mask(sz);
  endfunction

  task automatic rput(int sz, int spec, logic [31:0] v);
    int sh;
    if (sz == 0) begin
      sh = (spec >= 4) ? 8 : 0;
      exp_rf[spec % 4] = (exp_rf[spec % 4] & ~(32'hFF << sh)) | ((v & 32'hFF) << sh);
    end else begin
      exp_rf[spec] = mmerge(sz, exp_rf[spec], v);
    end
  endtask

  // Issue one instruction and follow it cycle by cycle.
  task automatic run(input string tag, input logic [7:0] opc, input logic [1:0] mdv,
                     input logic [2:0] rgv, input logic [2:0] rmv, input logic o32v,
                     input logic [31:0] eav, input int lat_r, input int lat_w, input bit poke);
    int sz, d, s;
    bit nop, is_mem, two_writes;
    logic [31:0] a, b, m;
    for (int i = 0; i < 8; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 16; i++) exp_mem[i] = mem_m[i];
    nop = 1'b1; is_mem = 1'b0; sz = 0; d = 0; s = 0;
    if (opc >= 8'h90 && opc <= 8'h97) begin
      nop = (opc == 8'h90); sz = o32v ? 2 : 1; d = 0; s = int'(opc) - 8'h90;
    end else if (opc == 8'h86 || opc == 8'h87) begin
      nop = 1'b0; is_mem = (mdv != 2'b11);
      sz = (opc == 8'h86) ? 0 : (o32v ? 2 : 1); d = int'(rgv); s = int'(rmv);
    end
    a = rget(sz, d);
    b = rget(sz, s);
    m = exp_mem[eav[3:0]] & size_mask(sz);
    two_writes = !nop && !is_mem && ((sz == 0) ? (d % 4 != s % 4) : (d != s));
    if (!nop) begin
      if (is_mem) begin
        rput(sz, d, m);
        exp_mem[eav[3:0]] = mmerge(sz, exp_mem[eav[3:0]], a);
      end else begin
        rput(sz, d, b);
        rput(sz, s, a);
      end
    end

    start = 1'b1; opcode = opc; md = mdv; rg = rgv; rm = rmv; o32 = o32v; ea = eav;
    @(negedge clk);
    start = 1'b0;
    if (is_mem) begin
      for (int c = 0; c <= lat_r; c++) begin
        chk("R7", "read lock", 32'(lock), 1);
        chk("R7", "read req", 32'(mreq), 1);
        chk("R7", "read we", 32'(mwe), 0);
        chk("R7", "read addr", maddr, eav);
        chk("R7", "read size", 32'(msize), 32'(sz));
        chk("R9", "done while reading", 32'(done), 0);
        mready = (c == lat_r);
        if (poke && c == 0) begin
          start = 1'b1; opcode = 8'h87; md = 2'b11; rg = 3'd1; rm = 3'd2; o32 = 1'b1;
        end
        @(negedge clk);
        mready = 1'b0; start = 1'b0;
      end
      for (int c = 0; c <= lat_w; c++) begin
        chk("R7", "write lock", 32'(lock), 1);
        chk("R7", "write req", 32'(mreq), 1);
        chk("R7", "write we", 32'(mwe), 1);
        chk("R7", "write addr", maddr, eav);
        chk("R7", "write data", mwdata, a);
        chk("R9", "done while writing", 32'(done), 0);
        mready = (c == lat_w);
        @(negedge clk);
        mready = 1'b0;
      end
      chk("R8", "done after write", 32'(done), 1);
      chk("R8", "lock dropped", 32'(lock), 0);
      chk("R8", "req dropped", 32'(mreq), 0);
      chk("R8", "reg write", 32'(we_a), 1);
    end else begin
      chk(tag, "done", 32'(done), 1);
      chk(tag, "no lock", 32'(lock), 0);
      chk(tag, "no mem req", 32'(mreq), 0);
      chk(tag, "write A", 32'(we_a), 32'(!nop));
      chk("R5", "write B", 32'(we_b), 32'(two_writes));
    end
    @(negedge clk);
    chk("R9", "done pulse ends", 32'(done), 0);
    for (int i = 0; i < 8; i++) chk(tag, $sformatf("reg %0d", i), rf[i], exp_rf[i]);
    chk(tag, "memory word", mem_m[eav[3:0]], exp_mem[eav[3:0]]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = '0; md = '0; rg = '0; rm = '0;
    o32 = 1'b0; ea = '0; mready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", 32'(done), 0);
    chk("R1", "lock in reset", 32'(lock), 0);
    chk("R1", "req in reset", 32'(mreq), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1", "idle outputs", 32'({done, lock, mreq, we_a, we_b}), 0);
    end

    run("R2", 8'h93, 2'b11, 3'd0, 3'd0, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R2", 8'h95, 2'b11, 3'd0, 3'd0, 1'b0, 32'd0, 0, 0, 1'b0);
    run("R3", 8'h90, 2'b11, 3'd0, 3'd0, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R4", 8'h86, 2'b11, 3'd1, 3'd6, 1'b0, 32'd0, 0, 0, 1'b0);
    run("R4", 8'h86, 2'b11, 3'd7, 3'd2, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R5", 8'h86, 2'b11, 3'd0, 3'd4, 1'b0, 32'd0, 0, 0, 1'b0);
    run("R5", 8'h86, 2'b11, 3'd5, 3'd5, 1'b0, 32'd0, 0, 0, 1'b0);
    run("R5", 8'h87, 2'b11, 3'd2, 3'd2, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R6", 8'h87, 2'b11, 3'd3, 3'd6, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R6", 8'h87, 2'b11, 3'd7, 3'd2, 1'b0, 32'd0, 0, 0, 1'b0);
    run("R7", 8'h86, 2'b00, 3'd7, 3'd0, 1'b0, 32'h0000_0005, 0, 0, 1'b0);
    run("R9", 8'h87, 2'b01, 3'd2, 3'd3, 1'b0, 32'h0000_0009, 2, 3, 1'b1);
    run("R8", 8'h87, 2'b10, 3'd6, 3'd1, 1'b1, 32'h0000_0003, 1, 0, 1'b0);
    run("R10", 8'h0F, 2'b11, 3'd1, 3'd2, 1'b1, 32'd0, 0, 0, 1'b0);
    run("R2", 8'h97, 2'b11, 3'd0, 3'd0, 1'b1, 32'd0, 0, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule